// File: doc/BRIEF.md
# Temperature Trim Interpolator

This block converts a digitised crystal temperature into the code that drives a frequency-trim DAC. The temperature arrives as a 12-bit two's-complement word with 1/16 degree per LSB. The block reads two neighbouring entries from an external calibration table, whose entries sit every half degree. It interpolates linearly between them down to the 1/16 degree step. It then adds a signed user tuning offset and clamps the result into the 14-bit DAC range.

Work is event-driven. A fresh result is computed only in three cases: when the temperature converter delivers a value different from the previous one, when software writes the tuning bytes, or once after reset. A freeze bit in the high tuning byte holds the temperature term at its last computed value. Conversions are still recorded while the bit is set, and tuning writes still reach the DAC. The table storage and the DAC itself are outside the block. The table is reached through a synchronous read port with one cycle of latency.

Top module: `tcxo_trim_interp`

## Requirements
- R1: After reset the block holds these values: DAC code 0, no valid pulse, no table read, stored temperature 400 (+25 °C), tuning 0. The block then runs one update on its own. Its valid pulse comes on the sixth rising edge after reset is released.
- R2: The temperature term is e0 + ((e1 − e0) × f) / 8, with the division rounded toward zero. Here e0 and e1 are the table entries at index i and i+1, and f is the fraction.
- R3: For temperature t (signed, 1/16 °C), let o = t + 640, clamped to 0..2000. Then i = o >> 3 and f = o & 7. The exception is o = 2000, which uses i = 249 and f = 8. Table addresses never exceed 250.
- R4: A conversion strobe starts an update only if its value differs from the last strobed value. A repeated value produces no valid pulse.
- R5: Every tuning write starts an update. The offset is the 15-bit two's-complement value {high[6:0], low[7:0]}, so high bit 6 is the sign and low bit 0 is the LSB. High bit 7 is the freeze bit.
- R6: The sum of the temperature term and the offset saturates to 0 below zero and to 16383 above 16383.
- R7: While the freeze bit is set, the temperature term keeps the value from the last update made before freezing. In that state, new conversions are stored but start no update, and tuning writes still update the DAC with the held term. Clearing the bit with a write recomputes the term from the latest stored conversion.
- R8: An update that starts from idle raises the one-cycle valid pulse on the sixth rising edge after the edge that sampled the strobe or write. The DAC code changes only together with the valid pulse.
- R9: Events that arrive during an update are merged into one pending update. That update starts on the edge after the valid pulse and uses the values stored at that time.
- R10: Each update issues exactly two table reads on consecutive cycles, to address i and then to address i+1. Read data is taken one cycle after each read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| temp_i | input | 12 | Converted temperature, two's complement, 1/16 °C |
| temp_stb_i | input | 1 | New conversion present on temp_i |
| tune_hi_i | input | 8 | Tuning high byte: bit 7 freeze, bits 6:0 offset upper part |
| tune_lo_i | input | 8 | Tuning low byte |
| tune_wr_i | input | 1 | Tuning bytes written |
| tbl_rd_o | output | 1 | Calibration table read request |
| tbl_addr_o | output | 8 | Calibration table entry index |
| tbl_data_i | input | 14 | Table entry, valid the cycle after the read |
| dac_code_o | output | 14 | Registered DAC code |
| dac_vld_o | output | 1 | One-cycle pulse when dac_code_o is new |

## Verification
The bench sweeps temperatures across all eight fractions over table segments that rise and fall. A design that floors negative steps instead of truncating them would be off by one on the falling segments. The bench drives the range edges: −640, −641, the extreme codes, 1359, 1360 and 1361. A wrong clamp shows up there as an address of 251 or as a wrong end value. Repeated identical conversions, conversions while frozen, and events landing mid-update are all applied. A design that retriggers, drops the merged event or misuses stale values would show a valid pulse in the wrong cycle. Tuning offsets at full positive and full negative scale check both saturation rails and the sign position.

// File: rtl/trim_pkg.sv
`timescale 1ns / 1ps
package trim_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR0  = 3'd1,
        ST_ADDR1  = 3'd2,
        ST_CAPT   = 3'd3,
        ST_INTERP = 3'd4,
        ST_SUM    = 3'd5
    } trim_state_e;
endpackage

// File: rtl/trim_event_ctrl.sv
`timescale 1ns / 1ps
// Holds the last conversion and the tuning bytes, and raises a pending
// update request on a changed conversion or on any tuning write.
module trim_event_ctrl #(
    parameter int TEMP_W     = 12,
    parameter int RESET_TEMP = 400
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              temp_stb_i,
    input  logic [7:0]        tune_hi_i,
    input  logic [7:0]        tune_lo_i,
    input  logic              tune_wr_i,
    input  logic              start_i,
    output logic [TEMP_W-1:0] temp_o,
    output logic [14:0]       tune_o,
    output logic              hold_o,
    output logic              pend_o
);
    typedef struct packed {
        logic [TEMP_W-1:0] temp;
        logic [7:0]        hi;
        logic [7:0]        lo;
        logic              pend;
    } ev_s;

    ev_s  st_d, st_q;
    logic temp_evt;

    always_comb begin
        st_d     = st_q;
        temp_evt = temp_stb_i && (temp_i != st_q.temp) && !st_q.hi[7];
        if (temp_stb_i) begin
            st_d.temp = temp_i;
        end
        if (tune_wr_i) begin
            st_d.hi = tune_hi_i;
            st_d.lo = tune_lo_i;
        end
        st_d.pend = temp_evt || tune_wr_i || (st_q.pend && !start_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.temp <= TEMP_W'(RESET_TEMP);
            st_q.hi   <= '0;
            st_q.lo   <= '0;
            st_q.pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign temp_o = st_q.temp;
    assign tune_o = {st_q.hi[6:0], st_q.lo};
    assign hold_o = st_q.hi[7];
    assign pend_o = st_q.pend;

    // R5: a tuning write always leaves an update pending
    p_write_arms_update_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tune_wr_i |=> pend_o);

    // R7: a conversion while frozen does not request an update
    p_frozen_temp_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_o && temp_stb_i && !tune_wr_i && !pend_o) |=> !pend_o);
endmodule

// File: rtl/trim_index_map.sv
`timescale 1ns / 1ps
// Maps a temperature to a table segment index and a 0..2^FRAC_B fraction,
// clamping outside the calibrated span.
module trim_index_map #(
    parameter int TEMP_W = 12,
    parameter int T_LO   = -640,
    parameter int T_HI   = 1360,
    parameter int FRAC_B = 3,
    parameter int ADDR_W = 8
) (
    input  logic [TEMP_W-1:0] temp_i,
    output logic [ADDR_W-1:0] idx_o,
    output logic [FRAC_B:0]   frac_o
);
    localparam int SPAN     = T_HI - T_LO;
    localparam int LAST_SEG = SPAN >> FRAC_B;
    localparam int OFF_W    = $clog2(SPAN + 1);
    localparam int EXT_W    = TEMP_W + 2;

    localparam logic signed [EXT_W-1:0] LO_V      = EXT_W'(T_LO);
    localparam logic signed [EXT_W-1:0] SPAN_V    = EXT_W'(SPAN);
    localparam logic [OFF_W-1:0]        SPAN_U    = OFF_W'(SPAN);
    localparam logic [OFF_W-1:0]        LAST_V    = OFF_W'(LAST_SEG);
    localparam logic [ADDR_W-1:0]       TOP_IDX   = ADDR_W'(LAST_SEG - 1);
    localparam logic [FRAC_B:0]         FRAC_FULL = {1'b1, {FRAC_B{1'b0}}};

    logic signed [EXT_W-1:0] off_w;
    logic [OFF_W-1:0]        off_c;
    logic [OFF_W-1:0]        seg;

    always_comb begin
        off_w = $signed({{2{temp_i[TEMP_W-1]}}, temp_i}) - LO_V;
        if (off_w[EXT_W-1]) begin
            off_c = '0;
        end else if (off_w > SPAN_V) begin
            off_c = SPAN_U;
        end else begin
            off_c = off_w[OFF_W-1:0];
        end
        seg = off_c >> FRAC_B;
        if (seg == LAST_V) begin
            idx_o  = TOP_IDX;
            frac_o = FRAC_FULL;
        end else begin
            idx_o  = seg[ADDR_W-1:0];
            frac_o = {1'b0, off_c[FRAC_B-1:0]};
        end
    end
endmodule

// File: rtl/trim_sat_add.sv
`timescale 1ns / 1ps
// Adds the signed tuning offset to the unsigned trim and clamps to the DAC range.
module trim_sat_add #(
    parameter int ENTRY_W = 14,
    parameter int TUNE_W  = 15,
    parameter int DAC_W   = 14
) (
    input  logic [ENTRY_W-1:0] trim_i,
    input  logic [TUNE_W-1:0]  tune_i,
    output logic [DAC_W-1:0]   code_o
);
    localparam int BASE_W = (ENTRY_W > TUNE_W) ? ENTRY_W : TUNE_W;
    localparam int SUM_W  = ((BASE_W > DAC_W) ? BASE_W : DAC_W) + 2;
    localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((1 << DAC_W) - 1);

    logic signed [SUM_W-1:0] trim_x, tune_x, sum_w;

    always_comb begin
        trim_x = $signed({{(SUM_W-ENTRY_W){1'b0}}, trim_i});
        tune_x = $signed({{(SUM_W-TUNE_W){tune_i[TUNE_W-1]}}, tune_i});
        sum_w  = trim_x + tune_x;
        if (sum_w[SUM_W-1]) begin
            code_o = '0;
        end else if (sum_w > MAX_V) begin
            code_o = '1;
        end else begin
            code_o = sum_w[DAC_W-1:0];
        end
    end
endmodule

// File: rtl/trim_interp_core.sv
`timescale 1ns / 1ps
// Sequencer: snapshot, two table reads, interpolation, saturated sum, output.
module trim_interp_core
    import trim_pkg::*;
#(
    parameter int ENTRY_W   = 14,
    parameter int DAC_W     = 14,
    parameter int ADDR_W    = 8,
    parameter int FRAC_B    = 3,
    parameter int TUNE_W    = 15,
    parameter int N_ENTRIES = 251
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               pend_i,
    input  logic               hold_i,
    input  logic [TUNE_W-1:0]  tune_i,
    input  logic [ADDR_W-1:0]  idx_i,
    input  logic [FRAC_B:0]    frac_i,
    output logic               start_o,
    output logic               tbl_rd_o,
    output logic [ADDR_W-1:0]  tbl_addr_o,
    input  logic [ENTRY_W-1:0] tbl_data_i,
    output logic [ENTRY_W-1:0] sat_trim_o,
    output logic [TUNE_W-1:0]  sat_tune_o,
    input  logic [DAC_W-1:0]   sat_code_i,
    output logic [DAC_W-1:0]   dac_code_o,
    output logic               dac_vld_o
);
    localparam int PROD_W = ENTRY_W + FRAC_B + 3;
    localparam logic signed [PROD_W-1:0] RND_V    = PROD_W'((1 << FRAC_B) - 1);
    localparam logic [ADDR_W-1:0]        LAST_IDX = ADDR_W'(N_ENTRIES - 1);

    typedef struct packed {
        trim_state_e        st;
        logic [ADDR_W-1:0]  idx;
        logic [FRAC_B:0]    frac;
        logic               hold;
        logic [TUNE_W-1:0]  tune;
        logic [ENTRY_W-1:0] e0;
        logic [ENTRY_W-1:0] e1;
        logic [ENTRY_W-1:0] trim;
        logic [DAC_W-1:0]   dac;
        logic               vld;
    } core_s;

    core_s q_d, q_q;

    logic signed [ENTRY_W:0]   diff_w;
    logic signed [PROD_W-1:0]  prod_w, adj_w, step_w, interp_w;

    // Linear interpolation, quotient truncated toward zero
    always_comb begin
        diff_w   = $signed({1'b0, q_q.e1}) - $signed({1'b0, q_q.e0});
        prod_w   = $signed({{(PROD_W-ENTRY_W-1){diff_w[ENTRY_W]}}, diff_w})
                 * $signed({{(PROD_W-FRAC_B-1){1'b0}}, q_q.frac});
        adj_w    = prod_w[PROD_W-1] ? (prod_w + RND_V) : prod_w;
        step_w   = adj_w >>> FRAC_B;
        interp_w = $signed({{(PROD_W-ENTRY_W){1'b0}}, q_q.e0}) + step_w;
    end

    always_comb begin
        q_d        = q_q;
        q_d.vld    = 1'b0;
        start_o    = 1'b0;
        tbl_rd_o   = 1'b0;
        tbl_addr_o = q_q.idx;
        case (q_q.st)
            ST_IDLE: begin
                if (pend_i) begin
                    start_o  = 1'b1;
                    q_d.st   = ST_ADDR0;
                    q_d.idx  = idx_i;
                    q_d.frac = frac_i;
                    q_d.hold = hold_i;
                    q_d.tune = tune_i;
                end
            end
            ST_ADDR0: begin
                tbl_rd_o = 1'b1;
                q_d.st   = ST_ADDR1;
            end
            ST_ADDR1: begin
                tbl_rd_o   = 1'b1;
                tbl_addr_o = q_q.idx + 1'b1;
                q_d.e0     = tbl_data_i;
                q_d.st     = ST_CAPT;
            end
            ST_CAPT: begin
                q_d.e1 = tbl_data_i;
                q_d.st = ST_INTERP;
            end
            ST_INTERP: begin
                if (!q_q.hold) begin
                    q_d.trim = interp_w[ENTRY_W-1:0];
                end
                q_d.st = ST_SUM;
            end
            ST_SUM: begin
                q_d.dac = sat_code_i;
                q_d.vld = 1'b1;
                q_d.st  = ST_IDLE;
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign sat_trim_o = q_q.trim;
    assign sat_tune_o = q_q.tune;
    assign dac_code_o = q_q.dac;
    assign dac_vld_o  = q_q.vld;

    // R8: the valid flag is a single-cycle pulse
    p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dac_vld_o |=> !dac_vld_o);

    // R8: fixed distance from the start of an update to its result
    p_fixed_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> ##6 dac_vld_o);

    // R8: the code only moves together with the valid pulse
    p_code_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dac_vld_o |-> $stable(dac_code_o));

    // R10: the second read follows the first at the next address
    p_read_pair_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_q.st == ST_ADDR0) |=> (tbl_rd_o && tbl_addr_o == $past(tbl_addr_o) + 1'b1));

    // R3: reads stay inside the table
    p_addr_in_table_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tbl_rd_o |-> (tbl_addr_o <= LAST_IDX));

    // R2: a fresh interpolated term lies between its two entries
    p_trim_between_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_q.st == ST_SUM && !q_q.hold) |->
        ((q_q.trim >= q_q.e0 && q_q.trim <= q_q.e1) ||
         (q_q.trim <= q_q.e0 && q_q.trim >= q_q.e1)));
endmodule

// File: rtl/tcxo_trim_interp.sv
`timescale 1ns / 1ps
module tcxo_trim_interp #(
    parameter int TEMP_W     = 12,
    parameter int ENTRY_W    = 14,
    parameter int DAC_W      = 14,
    parameter int FRAC_B     = 3,
    parameter int T_LO       = -640,
    parameter int T_HI       = 1360,
    parameter int RESET_TEMP = 400,
    localparam int N_ENTRIES = ((T_HI - T_LO) >> FRAC_B) + 1,
    localparam int ADDR_W    = $clog2(N_ENTRIES)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [TEMP_W-1:0]  temp_i,
    input  logic               temp_stb_i,
    input  logic [7:0]         tune_hi_i,
    input  logic [7:0]         tune_lo_i,
    input  logic               tune_wr_i,
    output logic               tbl_rd_o,
    output logic [ADDR_W-1:0]  tbl_addr_o,
    input  logic [ENTRY_W-1:0] tbl_data_i,
    output logic [DAC_W-1:0]   dac_code_o,
    output logic               dac_vld_o
);
    localparam int TUNE_W = 15;

    logic [TEMP_W-1:0]  temp_w;
    logic [TUNE_W-1:0]  tune_w;
    logic               hold_w, pend_w, start_w;
    logic [ADDR_W-1:0]  idx_w;
    logic [FRAC_B:0]    frac_w;
    logic [ENTRY_W-1:0] sat_trim_w;
    logic [TUNE_W-1:0]  sat_tune_w;
    logic [DAC_W-1:0]   sat_code_w;

    trim_event_ctrl #(
        .TEMP_W     (TEMP_W),
        .RESET_TEMP (RESET_TEMP)
    ) i_events (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .temp_i     (temp_i),
        .temp_stb_i (temp_stb_i),
        .tune_hi_i  (tune_hi_i),
        .tune_lo_i  (tune_lo_i),
        .tune_wr_i  (tune_wr_i),
        .start_i    (start_w),
        .temp_o     (temp_w),
        .tune_o     (tune_w),
        .hold_o     (hold_w),
        .pend_o     (pend_w)
    );

    trim_index_map #(
        .TEMP_W (TEMP_W),
        .T_LO   (T_LO),
        .T_HI   (T_HI),
        .FRAC_B (FRAC_B),
        .ADDR_W (ADDR_W)
    ) i_index (
        .temp_i (temp_w),
        .idx_o  (idx_w),
        .frac_o (frac_w)
    );

    trim_interp_core #(
        .ENTRY_W   (ENTRY_W),
        .DAC_W     (DAC_W),
        .ADDR_W    (ADDR_W),
        .FRAC_B    (FRAC_B),
        .TUNE_W    (TUNE_W),
        .N_ENTRIES (N_ENTRIES)
    ) i_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pend_i     (pend_w),
        .hold_i     (hold_w),
        .tune_i     (tune_w),
        .idx_i      (idx_w),
        .frac_i     (frac_w),
        .start_o    (start_w),
        .tbl_rd_o   (tbl_rd_o),
        .tbl_addr_o (tbl_addr_o),
        .tbl_data_i (tbl_data_i),
        .sat_trim_o (sat_trim_w),
        .sat_tune_o (sat_tune_w),
        .sat_code_i (sat_code_w),
        .dac_code_o (dac_code_o),
        .dac_vld_o  (dac_vld_o)
    );

    trim_sat_add #(
        .ENTRY_W (ENTRY_W),
        .TUNE_W  (TUNE_W),
        .DAC_W   (DAC_W)
    ) i_sat (
        .trim_i (sat_trim_w),
        .tune_i (sat_tune_w),
        .code_o (sat_code_w)
    );
endmodule

// File: tb/test_tcxo_trim_interp.sv
`timescale 1ns / 1ps
module test_tcxo_trim_interp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] temp = 12'd400;
    logic        stb = 1'b0;
    logic [7:0]  hi = 8'h00;
    logic [7:0]  lo = 8'h00;
    logic        wr = 1'b0;
    logic        tbl_rd;
    logic [7:0]  tbl_addr;
    logic [13:0] tbl_data = '0;
    logic [13:0] dac_code;
    logic        dac_vld;

    always #2.5 clk = ~clk;

    tcxo_trim_interp i_tcxo_trim_interp (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .temp_i     (temp),
        .temp_stb_i (stb),
        .tune_hi_i  (hi),
        .tune_lo_i  (lo),
        .tune_wr_i  (wr),
        .tbl_rd_o   (tbl_rd),
        .tbl_addr_o (tbl_addr),
        .tbl_data_i (tbl_data),
        .dac_code_o (dac_code),
        .dac_vld_o  (dac_vld)
    );

    // External calibration table with a one-cycle read
    function automatic int tbl_f(int k);
        return 3000 + ((k * k * 29 + k * 311) % 7919);
    endfunction

    always @(posedge clk) if (tbl_rd) tbl_data <= 14'(tbl_f(int'(tbl_addr)));

    function automatic int off_of(int t);
        int o;
        o = t + 640;
        if (o < 0) o = 0;
        if (o > 2000) o = 2000;
        return o;
    endfunction

    function automatic int idx_of(int t);
        int i;
        i = off_of(t) / 8;
        return (i == 250) ? 249 : i;
    endfunction

    function automatic int trim_of(int t);
        int o, i, f, e0, e1;
        o = off_of(t);
        i = o / 8;
        f = o % 8;
        if (i == 250) begin i = 249; f = 8; end
        e0 = tbl_f(i);
        e1 = tbl_f(i + 1);
        return e0 + ((e1 - e0) * f) / 8;
    endfunction

    function automatic int sat(int v);
        if (v < 0) return 0;
        if (v > 16383) return 16383;
        return v;
    endfunction

    // Behavioural reference model
    int   m_temp, m_trim, m_cnt, m_res, m_idx, exp_dac, exp_addr;
    logic [7:0] m_hi, m_lo;
    bit   m_pend, exp_vld, exp_rd;

    always @(posedge clk or negedge rst_n) begin
        bit start, ev;
        int tv;
        if (!rst_n) begin
            m_temp = 400; m_hi = 0; m_lo = 0; m_pend = 1; m_cnt = 0;
            m_trim = 0; m_res = 0; m_idx = 0; exp_vld = 0; exp_dac = 0;
            exp_rd = 0; exp_addr = 0;
        end else begin
            start = (m_cnt == 0) && m_pend;
            ev = (stb && (int'($signed(temp)) != m_temp) && !m_hi[7]) || wr;
            exp_vld = 0;
            if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin exp_vld = 1; exp_dac = m_res; end
            end
            if (start) begin
                if (!m_hi[7]) m_trim = trim_of(m_temp);
                tv = int'($signed({m_hi[6:0], m_lo}));
                m_res = sat(m_trim + tv);
                m_idx = idx_of(m_temp);
                m_cnt = 5;
            end
            exp_rd   = (m_cnt == 5) || (m_cnt == 4);
            exp_addr = (m_cnt == 5) ? m_idx : m_idx + 1;
            m_pend = ev || (m_pend && !start);
            if (stb) m_temp = int'($signed(temp));
            if (wr) begin m_hi = hi; m_lo = lo; end
        end
    end

    int    n_vec = 0, n_bad = 0;
    string tag = "R1";
    bit    done = 0;

    always @(negedge clk) begin
        if (!done) begin
            n_vec++;
            if (dac_vld !== exp_vld || int'(dac_code) != exp_dac || tbl_rd !== exp_rd ||
                (exp_rd && int'(tbl_addr) != exp_addr)) begin
                n_bad++;
                $display("FAIL %s t=%0t: vld=%0d/%0d code=%0d/%0d rd=%0d/%0d addr=%0d/%0d (actual/expected)",
                         tag, $time, dac_vld, exp_vld, dac_code, exp_dac, tbl_rd, exp_rd,
                         tbl_addr, exp_addr);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic conv(int t);
        @(negedge clk);
        temp = 12'(t);
        stb  = 1'b1;
        @(negedge clk);
        stb  = 1'b0;
    endtask

    task automatic tune(logic [7:0] h, logic [7:0] l);
        @(negedge clk);
        hi = h; lo = l; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
            finish_run();
        end
    end

    initial begin
        // R1: reset values, then the automatic first update at +25 C
        tag = "R1";
        idle(4);
        rst_n = 1'b1;
        idle(10);
        // R2: interpolation across all fractions, rising and falling segments
        tag = "R2";
        for (int t = -90; t <= 90; t += 3) begin conv(t); idle(7); end
        for (int t = 700; t <= 716; t++) begin conv(t); idle(7); end
        // R3: clamp and index mapping at the range edges
        tag = "R3";
        conv(-2048); idle(7); conv(-641); idle(7); conv(-640); idle(7);
        conv(-639);  idle(7); conv(1352); idle(7); conv(1359); idle(7);
        conv(1360);  idle(7); conv(1361); idle(7); conv(2047); idle(7);
        // R4: repeated identical conversions start nothing
        tag = "R4";
        conv(2047); idle(7); conv(2047); idle(7);
        conv(33); idle(7); conv(33); idle(7);
        // R5: tuning field layout and write-triggered updates
        tag = "R5";
        tune(8'h00, 8'h05); idle(7);
        tune(8'h01, 8'h23); idle(7);
        tune(8'h7F, 8'hFF); idle(7);
        tune(8'h00, 8'h05); idle(7);
        // R6: saturation at both rails
        tag = "R6";
        tune(8'h3F, 8'hFF); idle(7);
        tune(8'h40, 8'h00); idle(7);
        tune(8'h20, 8'h00); idle(7);
        // R7: freeze holds the temperature term, tuning stays live
        tag = "R7";
        tune(8'h80, 8'h10); idle(7);
        conv(100);  idle(7);
        conv(-300); idle(7);
        tune(8'h80, 8'h40); idle(7);
        tune(8'hC0, 8'h00); idle(7);
        tune(8'h00, 8'h20); idle(7);
        // R8: latency and pulse shape from idle
        tag = "R8";
        conv(512); idle(9); tune(8'h00, 8'h00); idle(9);
        // R9: events landing during an update are merged and deferred
        tag = "R9";
        conv(480); idle(1); conv(496); tune(8'h00, 8'h77); idle(16);
        for (int k = 0; k < 6; k++) tune(8'h00, 8'(k));
        idle(16);
        // R10: paired table reads on adjacent addresses
        tag = "R10";
        conv(-7); idle(7); conv(1000); idle(7); conv(0); idle(7);
        finish_run();
    end
endmodule